// File: doc/BRIEF.md
# Interrupt Distributor Priority Scanner

This block sits between a set of peripheral interrupt lines and one processor-side interface. Each line is tracked as pending in one of two ways. In edge mode a rising edge latches the line as pending. In level mode the line counts as pending for as long as it is high. A scanning engine then walks the interrupt numbers one per clock. It keeps a running best candidate among the lines that are pending, enabled and not already being serviced. When the walk completes, it publishes the winner's number and priority. While a global forwarding switch is on, that result is shown to the processor side.

The processor side reports two events to the block. It acknowledges an interrupt, which marks it in service and consumes an edge-mode pending latch. It later reports completion, which takes the interrupt out of service. Configuration goes through a plain write port that selects a field, an interrupt number and a data byte.

The output is a plain status bundle, not a stream. `hp_valid`, `hp_id` and `hp_prio` always show the last published result, and nothing here can stall the scanner. `ack_valid` and `done_valid` are one-cycle strobes that have no ready signal and are always accepted.

Top module: `irq_dist_scanner`

## Requirements
- R1: After reset, `hp_id` is 1023 (the "nothing pending" number), `hp_prio` is 8'hFF and `hp_valid` is 0.
- R2: A line in level mode (trigger bit 0) is pending exactly while its input is high. Once the input drops, it stops being reported after the next completed pass.
- R3: A line in edge mode (trigger bit 1) becomes pending on a 0-to-1 transition of its input. It stays pending after the input falls, until an acknowledge names it.
- R4: A line competes only when it is pending, its enable bit is 1 and it is not in service.
- R5: The winner is the competing line with the numerically lowest priority value. Among equal priorities, the lowest interrupt number wins.
- R6: A line whose priority is 8'hFF never wins, because a candidate must be strictly better than the 8'hFF starting value.
- R7: When the forward-enable bit is 0, the outputs show 1023 / 8'hFF / `hp_valid`=0 regardless of pending lines.
- R8: `ack_valid` with `ack_id` puts that interrupt in service. `done_valid` with `done_id` takes it out of service. A level line that is still high competes again after completion.
- R9: A pass lasts NUM_IRQ+1 cycles: NUM_IRQ scan steps plus one publish step. The outputs change only at publish steps, so any two output changes are a multiple of NUM_IRQ+1 cycles apart.
- R10: A configuration write uses `cfg_field` to select what it sets: 0 sets the enable bit (`cfg_wdata[0]`), 1 sets the priority (`cfg_wdata`), 2 sets the trigger mode (`cfg_wdata[0]`, 1 = edge), and 3 sets the global forward enable (`cfg_wdata[0]`, `cfg_id` ignored). Writes that name an interrupt number at or above NUM_IRQ have no effect.
- R11: Whenever `hp_valid` is 1, `hp_id` is below NUM_IRQ and `hp_prio` is not 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Peripheral interrupt lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 2 | Field selector (see R10) |
| cfg_id | input | ID_W | Interrupt number the write targets |
| cfg_wdata | input | PRIO_W | Write data |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | ID_W | Interrupt being acknowledged |
| done_valid | input | 1 | Completion strobe |
| done_id | input | ID_W | Interrupt being completed |
| hp_valid | output | 1 | A forwarded interrupt is presented |
| hp_id | output | ID_W | Presented interrupt number, 1023 when none |
| hp_prio | output | PRIO_W | Presented priority, 8'hFF when none |

## Verification
The hardest case to reach from the ports is the pass-boundary timing. The scan position cannot be seen, so the spacing of output changes is the only evidence that results are held between passes. The bench keeps a free-running cycle counter. It raises a high-urgency level line and records the cycle in which the output switches to it. After an arbitrary delay it drops the line and records the switch back. The gap between the two switches must be a whole number of passes. The in-service exclusion needs ordered strobes: an acknowledge while the line is held high, a check that the line vanishes, then a completion that brings it back.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
  localparam logic [PRIO_W-1:0] IDLE_PRIO   = '1;

  typedef enum logic [1:0] {
    FLD_ENABLE  = 2'd0,
    FLD_PRIO    = 2'd1,
    FLD_TRIGGER = 2'd2,
    FLD_FORWARD = 2'd3
  } cfg_field_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_field,
  input  logic [ID_W-1:0]           cfg_id,
  input  logic [PRIO_W-1:0]         cfg_wdata,
  output logic [NUM_IRQ-1:0]        enable_o,
  output logic [NUM_IRQ-1:0]        edge_mode_o,
  output logic [NUM_IRQ*PRIO_W-1:0] prio_flat_o,
  output logic                      fwd_en_o
);
  logic id_ok;
  assign id_ok = (cfg_id < ID_W'(NUM_IRQ));

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic hit;
    assign hit = cfg_we && id_ok && (cfg_id == ID_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        enable_o[i]                       <= 1'b0;
        edge_mode_o[i]                    <= 1'b0;
        prio_flat_o[i*PRIO_W +: PRIO_W]   <= IDLE_PRIO;
      end else if (hit) begin
        case (cfg_field_e'(cfg_field))
          FLD_ENABLE:  enable_o[i]                     <= cfg_wdata[0];
          FLD_PRIO:    prio_flat_o[i*PRIO_W +: PRIO_W] <= cfg_wdata;
          FLD_TRIGGER: edge_mode_o[i]                  <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      fwd_en_o <= 1'b0;
    else if (cfg_we && cfg_field_e'(cfg_field) == FLD_FORWARD)
      fwd_en_o <= cfg_wdata[0];
  end
endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] enable_i,
  input  logic [NUM_IRQ-1:0] edge_mode_i,
  input  logic               ack_valid,
  input  logic [ID_W-1:0]    ack_id,
  input  logic               done_valid,
  input  logic [ID_W-1:0]    done_id,
  output logic [NUM_IRQ-1:0] eligible_o
);
  logic [NUM_IRQ-1:0] prev_q, edge_pend_q, active_q, rise, pending;

  assign rise = irq_in & ~prev_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic ack_hit, done_hit;
    assign ack_hit  = ack_valid  && (ack_id  == ID_W'(i));
    assign done_hit = done_valid && (done_id == ID_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[i]      <= 1'b0;
        edge_pend_q[i] <= 1'b0;
        active_q[i]    <= 1'b0;
      end else begin
        prev_q[i]      <= irq_in[i];
        edge_pend_q[i] <= rise[i] | (edge_pend_q[i] & ~ack_hit);
        active_q[i]    <= ack_hit | (active_q[i] & ~done_hit);
      end
    end

    assign pending[i] = edge_mode_i[i] ? edge_pend_q[i] : irq_in[i];

    // R3: an acknowledge without a fresh rising edge consumes the latch
    AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !rise[i]) |=> !edge_pend_q[i]); // R3

    // R8: completion without a same-cycle acknowledge leaves the line idle
    AST_DONE_CLEARS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_hit && !ack_hit) |=> !active_q[i]); // R8
  end

  assign eligible_o = pending & enable_i & ~active_q;
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        eligible_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat_i,
  output logic [ID_W-1:0]           res_id_o,
  output logic [PRIO_W-1:0]         res_prio_o
);
  localparam int IDX_W = $clog2(NUM_IRQ + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_IRQ);

  logic [IDX_W-1:0]            idx_q;
  logic [ID_W-1:0]             cand_id_q;
  logic [PRIO_W-1:0]           cand_prio_q;
  logic [NUM_IRQ:0]            elig_ext;
  logic [(NUM_IRQ+1)*PRIO_W-1:0] prio_ext;
  logic                        pass_end, take;
  logic [PRIO_W-1:0]           cur_prio;

  assign elig_ext = {1'b0, eligible_i};
  assign prio_ext = {IDLE_PRIO, prio_flat_i};
  assign pass_end = (idx_q == LAST_IDX);
  assign cur_prio = prio_ext[idx_q*PRIO_W +: PRIO_W];
  assign take     = !pass_end && elig_ext[idx_q] && (cur_prio < cand_prio_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q       <= '0;
      cand_id_q   <= SPURIOUS_ID;
      cand_prio_q <= IDLE_PRIO;
      res_id_o    <= SPURIOUS_ID;
      res_prio_o  <= IDLE_PRIO;
    end else if (pass_end) begin
      res_id_o    <= cand_id_q;
      res_prio_o  <= cand_prio_q;
      idx_q       <= '0;
      cand_id_q   <= SPURIOUS_ID;
      cand_prio_q <= IDLE_PRIO;
    end else begin
      if (take) begin
        cand_id_q   <= ID_W'(idx_q);
        cand_prio_q <= cur_prio;
      end
      idx_q <= idx_q + 1'b1;
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX); // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_end |=> ($stable(res_id_o) && $stable(res_prio_o))); // R9

  AST_CAND_NEVER_WORSE: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_end |=> cand_prio_q <= $past(cand_prio_q)); // R5
endmodule

// File: rtl/irq_dist_scanner.sv
module irq_dist_scanner
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_field,
  input  logic [ID_W-1:0]    cfg_id,
  input  logic [PRIO_W-1:0]  cfg_wdata,
  input  logic               ack_valid,
  input  logic [ID_W-1:0]    ack_id,
  input  logic               done_valid,
  input  logic [ID_W-1:0]    done_id,
  output logic               hp_valid,
  output logic [ID_W-1:0]    hp_id,
  output logic [PRIO_W-1:0]  hp_prio
);
  logic [NUM_IRQ-1:0]        enable, edge_mode, eligible;
  logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
  logic                      fwd_en;
  logic [ID_W-1:0]           res_id;
  logic [PRIO_W-1:0]         res_prio;

  irq_cfg_regs #(.NUM_IRQ(NUM_IRQ)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
    .cfg_id(cfg_id), .cfg_wdata(cfg_wdata), .enable_o(enable),
    .edge_mode_o(edge_mode), .prio_flat_o(prio_flat), .fwd_en_o(fwd_en)
  );

  irq_pend_track #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .enable_i(enable),
    .edge_mode_i(edge_mode), .ack_valid(ack_valid), .ack_id(ack_id),
    .done_valid(done_valid), .done_id(done_id), .eligible_o(eligible)
  );

  irq_prio_scan #(.NUM_IRQ(NUM_IRQ)) u_scan (
    .clk(clk), .rst_n(rst_n), .eligible_i(eligible), .prio_flat_i(prio_flat),
    .res_id_o(res_id), .res_prio_o(res_prio)
  );

  assign hp_valid = fwd_en && (res_id != SPURIOUS_ID);
  assign hp_id    = hp_valid ? res_id : SPURIOUS_ID;
  assign hp_prio  = hp_valid ? res_prio : IDLE_PRIO;

  AST_VALID_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hp_valid |-> (hp_id < ID_W'(NUM_IRQ))); // R11

  AST_VALID_PRIO_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    hp_valid |-> (hp_prio != IDLE_PRIO)); // R6
endmodule

// File: tb/irq_dist_scanner_test.sv
module irq_dist_scanner_test;
  localparam int N      = 32;
  localparam int SETTLE = 2 * (N + 1) + 4;

  typedef struct {
    logic       valid;
    logic [9:0] id;
    logic [7:0] prio;
    string      tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0;
  logic cfg_we = 0, ack_valid = 0, done_valid = 0;
  logic [1:0] cfg_field = '0;
  logic [9:0] cfg_id = '0, ack_id = '0, done_id = '0;
  logic [7:0] cfg_wdata = '0;
  logic hp_valid;
  logic [9:0] hp_id;
  logic [7:0] hp_prio;

  int errors = 0, checks = 0, cyc = 0;
  exp_t sb[$];

  bit       en_m[N], edge_m[N], epend_m[N], act_m[N];
  bit [7:0] prio_m[N];
  bit       fwd_m = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_dist_scanner #(.NUM_IRQ(N)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_field(cfg_field), .cfg_id(cfg_id), .cfg_wdata(cfg_wdata),
    .ack_valid(ack_valid), .ack_id(ack_id), .done_valid(done_valid),
    .done_id(done_id), .hp_valid(hp_valid), .hp_id(hp_id), .hp_prio(hp_prio)
  );

  task automatic wr(input int fld, input int id, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_field = 2'(fld); cfg_id = 10'(id); cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_we = 0;
    if (fld == 3) fwd_m = data[0];
    else if (id < N) begin
      if (fld == 0) en_m[id] = data[0];
      if (fld == 1) prio_m[id] = 8'(data);
      if (fld == 2) edge_m[id] = data[0];
    end
  endtask

  task automatic line(input int id, input bit v);
    @(negedge clk);
    if (v && !irq_in[id]) epend_m[id] = 1;
    irq_in[id] = v;
  endtask

  task automatic ack(input int id);
    @(negedge clk);
    ack_valid = 1; ack_id = 10'(id);
    @(negedge clk);
    ack_valid = 0;
    epend_m[id] = 0; act_m[id] = 1;
  endtask

  task automatic done(input int id);
    @(negedge clk);
    done_valid = 1; done_id = 10'(id);
    @(negedge clk);
    done_valid = 0;
    act_m[id] = 0;
  endtask

  // driver: compute expectation from mirrors, push, wait for the monitor
  task automatic expect_now(input string tag);
    exp_t e;
    e.valid = 0; e.id = 10'd1023; e.prio = 8'hFF; e.tag = tag;
    if (fwd_m) begin
      for (int i = 0; i < N; i++) begin
        bit p = edge_m[i] ? epend_m[i] : irq_in[i];
        if (p && en_m[i] && !act_m[i] && prio_m[i] < e.prio) begin
          e.id = 10'(i); e.prio = prio_m[i]; e.valid = 1;
        end
      end
    end
    sb.push_back(e);
    while (sb.size() != 0) @(negedge clk);
  endtask

  // monitor: let two passes complete, then compare
  initial begin
    forever begin
      while (sb.size() == 0) @(negedge clk);
      repeat (SETTLE) @(posedge clk);
      @(negedge clk);
      checks++;
      if (hp_valid !== sb[0].valid || hp_id !== sb[0].id || hp_prio !== sb[0].prio) begin
        errors++;
        $display("FAIL %s: got valid=%0b id=%0d prio=%0h, expected valid=%0b id=%0d prio=%0h",
                 sb[0].tag, hp_valid, hp_id, hp_prio, sb[0].valid, sb[0].id, sb[0].prio);
      end
      void'(sb.pop_front());
    end
  end

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c1, c2;
    for (int i = 0; i < N; i++) prio_m[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (hp_valid !== 0 || hp_id !== 10'd1023 || hp_prio !== 8'hFF) begin
      errors++;
      $display("FAIL R1: got %0b/%0d/%0h, expected 0/1023/ff", hp_valid, hp_id, hp_prio);
    end
    expect_now("R1 idle after reset");

    // R10: configure; line 5 level prio 40
    wr(1, 5, 8'h40); wr(0, 5, 1); wr(3, 0, 1);
    line(5, 1);
    expect_now("R2 level line high");

    // R3: edge line 9, pulse only
    wr(2, 9, 1); wr(1, 9, 8'h20); wr(0, 9, 1);
    line(9, 1); line(9, 0);
    expect_now("R3 edge latched after pulse");

    // R5: tie between 3 and 7
    wr(1, 3, 8'h10); wr(1, 7, 8'h10); wr(0, 3, 1); wr(0, 7, 1);
    line(7, 1); line(3, 1);
    expect_now("R5 equal priority lower id");

    // R4: better priority but disabled
    wr(1, 12, 8'h01); line(12, 1);
    expect_now("R4 disabled line ignored");

    // R7: forward off
    wr(3, 0, 0);
    expect_now("R7 forward disabled");
    wr(3, 0, 1);

    // R8: in service exclusion, level line 3 remains high
    ack(3);
    expect_now("R8 acknowledged line excluded");
    done(3);
    expect_now("R8 completed level line competes again");

    // R2: drop level lines 3 and 7
    line(3, 0); line(7, 0);
    expect_now("R2 level line dropped");

    // R3: ack consumes the edge latch for line 9
    ack(9); done(9);
    expect_now("R3 edge latch consumed by ack");

    // R6: priority FF never wins (only line 20 pending among enabled)
    line(5, 0);
    wr(1, 20, 8'hFF); wr(0, 20, 1); line(20, 1);
    expect_now("R6 priority ff not forwarded");

    // R11/R5: top index wins with best priority
    wr(1, N-1, 8'h00); wr(0, N-1, 1); line(N-1, 1);
    expect_now("R11 last index wins");

    // R10: out of range write leaves state unchanged
    wr(1, N, 8'h00); wr(0, N, 0);
    expect_now("R10 out of range write ignored");

    // R9: output changes spaced by whole passes
    line(N-1, 0);
    expect_now("R9 baseline");
    wr(1, 2, 8'h02); wr(0, 2, 1);
    @(negedge clk); irq_in[2] = 1;
    while (hp_id != 10'd2) @(negedge clk);
    c1 = cyc;
    repeat (7) @(negedge clk);
    irq_in[2] = 0;
    while (hp_id == 10'd2) @(negedge clk);
    c2 = cyc;
    checks++;
    if (((c2 - c1) % (N + 1)) != 0) begin
      errors++;
      $display("FAIL R9: got change gap %0d, expected multiple of %0d", c2 - c1, N + 1);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule